// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block holds the pending-interrupt flags and the interrupt enables of a small peripheral that has several internal event sources, such as two counters and a serial shifter. Each source gives a one-cycle set pulse when its event occurs, and the matching flag stays set until something clears it. Software clears a flag by writing a one to its bit in the flag register. The owning blocks can also clear flags through dedicated clear strobes, as a side effect of their own register accesses.

Both registers are reached through one byte-wide register port. The top bit has its own meaning on each side. On an enable write it chooses between setting and clearing the selected enables. On a flag read it returns a summary bit, which is high when some enabled flag is pending. A single level-sensitive interrupt request leaves the block. By default it comes from a register.

The number of sources `SRC_CNT` may be 1 to 7. The parameter `IRQ_REGISTERED` chooses between a registered request output and a combinational one.

Top module: `irq_flag_ctrl`

## Requirements
- R1: A one-cycle pulse on bit i of `src_set` makes flag i read back as 1 from the next clock edge on.
- R2: A write with `reg_sel`=0 (the flag register) clears every flag whose bit in `reg_wdata` is 1. Flags whose written bit is 0 keep their value. Written bit 7 has no effect.
- R3: A write with `reg_sel`=1 (the enable register) and `reg_wdata[7]`=1 sets every enable whose bit in `reg_wdata[6:0]` is 1 and leaves the other enables unchanged.
- R4: A write with `reg_sel`=1 and `reg_wdata[7]`=0 clears every enable whose bit in `reg_wdata` is 1 and leaves the other enables unchanged.
- R5: With `reg_sel`=1, `reg_rdata` returns bit 7 as 1, enable i on bit i, and 0 on bits from `SRC_CNT` to 6.
- R6: With `reg_sel`=0, `reg_rdata` returns flag i on bit i and 0 on bits from `SRC_CNT` to 6. Bit 7 is 1 exactly when some flag and its enable are both 1.
- R7: While `rst_n` is low, all flags and all enables are 0 and `irq` is 0.
- R8: When a set pulse and a clear request for the same flag occur in the same cycle, the flag is 1 after the edge. The clear request may come from a strobe or from a write of one.
- R9: With `IRQ_REGISTERED`=1, `irq` in each cycle equals the OR over i of (flag i AND enable i) as it stood in the previous cycle, so `irq` follows any register change by one clock.
- R10: A pulse on bit i of `src_clr` with no set pulse on the same bit clears flag i at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_set | input | SRC_CNT | One-cycle set pulses from the event sources |
| src_clr | input | SRC_CNT | One-cycle clear strobes from the owning blocks |
| reg_sel | input | 1 | Register select: 0 selects the flags, 1 selects the enables |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The bench aims at the bit-7 cases.

- An enable write with bit 7 low must clear enables, not OR them in. A design that ignored the mode bit would leave sources enabled after software tried to mask them.
- The flag summary bit must track enabled flags only. A design that ORed every flag would report an interrupt from a masked source.
- A set pulse that arrives together with a strobe or write-one clear must win. Otherwise an event that lands during a software acknowledge would be lost.
- The bench checks the one-cycle lag of `irq` on every clock. A design with no output register, or with two, shows up as a mismatch.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned BYTE_W      = 8;
   localparam int unsigned SUMMARY_BIT = 7;
   localparam int unsigned MAX_SRC     = 7;

   typedef enum logic {
      SEL_FLAGS  = 1'b0,
      SEL_ENABLE = 1'b1
   } irqc_sel_e;
endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
   parameter int unsigned SRC_CNT = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SRC_CNT-1:0] set_i,
   input  logic [SRC_CNT-1:0] strobe_clr_i,
   input  logic [SRC_CNT-1:0] write_clr_i,
   output logic [SRC_CNT-1:0] flags_o
);
   logic [SRC_CNT-1:0] flags_q;
   logic [SRC_CNT-1:0] clr_mask;
   logic [SRC_CNT-1:0] flags_d;

   always_comb begin
      clr_mask = strobe_clr_i | write_clr_i;
      // set wins over any clear on the same bit
      flags_d  = (flags_q & ~clr_mask) | set_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_d;
   end

   assign flags_o = flags_q;

   // R8 / R1: every pulsed bit is set after the edge
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));

   // R10 and R2: a cleared bit without a concurrent set ends up 0
   a_r10_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
      (|((strobe_clr_i | write_clr_i) & ~set_i))
      |=> ((flags_q & $past((strobe_clr_i | write_clr_i) & ~set_i)) == '0));

   // R2: bits with neither set nor clear hold their value
   a_r2_untouched_hold: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags_q & ~$past(set_i | strobe_clr_i | write_clr_i))
                == ($past(flags_q) & ~$past(set_i | strobe_clr_i | write_clr_i))));
endmodule

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank #(
   parameter int unsigned SRC_CNT = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic               mode_set_i,
   input  logic [SRC_CNT-1:0] bits_i,
   output logic [SRC_CNT-1:0] en_o
);
   logic [SRC_CNT-1:0] en_q;
   logic [SRC_CNT-1:0] en_d;

   always_comb begin
      en_d = en_q;
      if (wr_i) begin
         if (mode_set_i) en_d = en_q | bits_i;
         else            en_d = en_q & ~bits_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d;
   end

   assign en_o = en_q;

   a_r3_set_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && mode_set_i) |=> ((en_q & $past(bits_i)) == $past(bits_i)));

   a_r4_clear_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !mode_set_i) |=> ((en_q & $past(bits_i)) == '0));

   // R3/R4: unselected enables never move
   a_r4_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((en_q & ~$past(wr_i ? bits_i : '0))
                == ($past(en_q) & ~$past(wr_i ? bits_i : '0))));
endmodule

// File: rtl/irqc_read_mux.sv
module irqc_read_mux
   import irqc_pkg::*;
#(
   parameter int unsigned SRC_CNT = 7
) (
   input  irqc_sel_e          sel_i,
   input  logic [SRC_CNT-1:0] flags_i,
   input  logic [SRC_CNT-1:0] en_i,
   output logic               summary_o,
   output logic [BYTE_W-1:0]  rdata_o
);
   logic [SUMMARY_BIT-1:0] flags_pad;
   logic [SUMMARY_BIT-1:0] en_pad;

   for (genvar i = 0; i < SUMMARY_BIT; i++) begin : g_pad
      if (i < SRC_CNT) begin : g_live
         assign flags_pad[i] = flags_i[i];
         assign en_pad[i]    = en_i[i];
      end else begin : g_zero
         assign flags_pad[i] = 1'b0;
         assign en_pad[i]    = 1'b0;
      end
   end

   assign summary_o = |(flags_i & en_i);

   always_comb begin
      if (sel_i == SEL_ENABLE) rdata_o = {1'b1, en_pad};
      else                     rdata_o = {summary_o, flags_pad};
   end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned SRC_CNT        = 7,
   parameter bit          IRQ_REGISTERED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SRC_CNT-1:0] src_set,
   input  logic [SRC_CNT-1:0] src_clr,
   input  logic               reg_sel,
   input  logic               reg_wr,
   input  logic [7:0]         reg_wdata,
   output logic [7:0]         reg_rdata,
   output logic               irq
);
   if (SRC_CNT < 1 || SRC_CNT > MAX_SRC) begin : g_bad_cnt
      $error("irq_flag_ctrl: SRC_CNT must be 1..7");
   end

   irqc_sel_e          sel;
   logic               wr_flags;
   logic               wr_enable;
   logic [SRC_CNT-1:0] write_clr;
   logic [SRC_CNT-1:0] flags;
   logic [SRC_CNT-1:0] en;
   logic               summary;

   assign sel       = irqc_sel_e'(reg_sel);
   assign wr_flags  = reg_wr && (sel == SEL_FLAGS);
   assign wr_enable = reg_wr && (sel == SEL_ENABLE);
   assign write_clr = wr_flags ? reg_wdata[SRC_CNT-1:0] : '0;

   irqc_flag_bank #(.SRC_CNT(SRC_CNT)) u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .set_i        (src_set),
      .strobe_clr_i (src_clr),
      .write_clr_i  (write_clr),
      .flags_o      (flags)
   );

   irqc_enable_bank #(.SRC_CNT(SRC_CNT)) u_enable (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (wr_enable),
      .mode_set_i (reg_wdata[SUMMARY_BIT]),
      .bits_i     (reg_wdata[SRC_CNT-1:0]),
      .en_o       (en)
   );

   irqc_read_mux #(.SRC_CNT(SRC_CNT)) u_rmux (
      .sel_i     (sel),
      .flags_i   (flags),
      .en_i      (en),
      .summary_o (summary),
      .rdata_o   (reg_rdata)
   );

   if (IRQ_REGISTERED) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= summary;
      end
      assign irq = irq_q;

      a_r9_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq == $past(summary)));

      // R6: the flag summary bit read now predicts the request next cycle
      a_r6_summary_next: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_sel == 1'b0) |=> (irq == $past(reg_rdata[SUMMARY_BIT])));
   end else begin : g_irq_comb
      assign irq = summary;
   end

   a_r5_enable_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
      reg_sel |-> reg_rdata[SUMMARY_BIT]);

   a_r7_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!irq && (flags == '0) && (en == '0)));
endmodule

// File: tb/irq_flag_ctrl_tb_top.sv
module irq_flag_ctrl_tb_top;
   localparam int PERIOD = 10;
   localparam int NSRC   = 7;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src_set = '0;
   logic [NSRC-1:0] src_clr = '0;
   logic            reg_sel = 1'b0;
   logic            reg_wr = 1'b0;
   logic [7:0]      reg_wdata = '0;
   logic [7:0]      reg_rdata;
   logic            irq;

   int n_checks = 0;
   int n_fail   = 0;

   // behavioural reference state
   int m_flags = 0;
   int m_en    = 0;
   int m_irq   = 0;

   always #(PERIOD/2) clk = ~clk;

   irq_flag_ctrl #(.SRC_CNT(NSRC), .IRQ_REGISTERED(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
      .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_flags = 0; m_en = 0; m_irq = 0;
      end else begin
         int clr;
         m_irq = ((m_flags & m_en) != 0) ? 1 : 0;
         clr = int'(src_clr);
         if (reg_wr && !reg_sel) clr = clr | (int'(reg_wdata) & 8'h7f);
         m_flags = ((m_flags & ~clr) | int'(src_set)) & 8'h7f;
         if (reg_wr && reg_sel) begin
            if (reg_wdata[7]) m_en = (m_en | int'(reg_wdata)) & 8'h7f;
            else              m_en = m_en & ~int'(reg_wdata) & 8'h7f;
         end
      end
   end

   function automatic int model_read(input logic sel);
      if (sel) return 8'h80 | m_en;
      return (((m_flags & m_en) != 0) ? 8'h80 : 0) | m_flags;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the edge
   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         check("R9 irq vs model", int'(irq), m_irq);
         check(reg_sel ? "R5 enable read vs model" : "R6 flag read vs model",
               int'(reg_rdata), model_read(reg_sel));
      end
   end

   task automatic drive(input logic sel, input logic wr, input logic [7:0] wd,
                        input logic [NSRC-1:0] st, input logic [NSRC-1:0] cl);
      @(negedge clk);
      reg_sel = sel; reg_wr = wr; reg_wdata = wd; src_set = st; src_clr = cl;
   endtask

   task automatic expect_read(input logic sel, input int exp, input string req);
      drive(sel, 1'b0, 8'h00, '0, '0);
      #2;
      check(req, int'(reg_rdata), exp);
   endtask

   task automatic expect_irq(input int exp, input string req);
      drive(reg_sel, 1'b0, 8'h00, '0, '0);
      #2;
      check(req, int'(irq), exp);
   endtask

   initial begin
      #(PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R7 reset irq", int'(irq), 0);
      check("R7 reset flag read", int'(reg_rdata), 8'h00);
      @(negedge clk); rst_n = 1'b1;
      expect_read(1'b0, 8'h00, "R7 flags after reset");
      expect_read(1'b1, 8'h80, "R7 enables after reset");

      drive(1'b1, 1'b1, 8'h85, '0, '0);           // R3 set enables 0,2
      expect_read(1'b1, 8'h85, "R3 set mode");

      drive(1'b0, 1'b0, 8'h00, 7'h02, '0);        // R1 masked source
      expect_read(1'b0, 8'h02, "R1 flag set, R6 summary low");
      expect_irq(0, "R9 masked flag keeps irq low");

      drive(1'b0, 1'b0, 8'h00, 7'h04, '0);        // enabled source
      expect_read(1'b0, 8'h86, "R6 summary high");
      expect_irq(1, "R9 irq after enabled flag");

      drive(1'b0, 1'b1, 8'h84, '0, '0);           // R2 clear bit2, bit7 ignored
      expect_read(1'b0, 8'h02, "R2 write-one clear");

      drive(1'b0, 1'b0, 8'h00, 7'h04, 7'h04);     // R8 set vs strobe
      expect_read(1'b0, 8'h86, "R8 set beats strobe");
      drive(1'b0, 1'b1, 8'h04, 7'h04, '0);        // R8 set vs write clear
      expect_read(1'b0, 8'h86, "R8 set beats write clear");

      drive(1'b0, 1'b0, 8'h00, '0, 7'h02);        // R10 strobe clear
      expect_read(1'b0, 8'h84, "R10 strobe clear");

      drive(1'b1, 1'b1, 8'h04, '0, '0);           // R4 clear enable 2
      expect_read(1'b1, 8'h81, "R4 clear mode");
      expect_read(1'b0, 8'h04, "R6 summary after mask");
      expect_irq(0, "R9 irq drops after mask");

      drive(1'b1, 1'b1, 8'hff, '0, '0);
      expect_read(1'b1, 8'hff, "R5 all enables");
      drive(1'b1, 1'b1, 8'h7f, '0, '0);
      expect_read(1'b1, 8'h80, "R4 clear all enables");

      for (int k = 0; k < 400; k++) begin
         drive(1'($urandom), 1'(($urandom % 3) == 0), 8'($urandom),
               7'($urandom & $urandom), 7'($urandom & $urandom & $urandom));
      end

      drive(1'b1, 1'b1, 8'hff, 7'h7f, '0);
      drive(1'b0, 1'b0, 8'h00, '0, '0);
      @(negedge clk); rst_n = 1'b0;
      #2;
      check("R7 mid-run reset irq", int'(irq), 0);
      check("R7 mid-run reset flags", int'(reg_rdata), 8'h00);
      reg_sel = 1'b1; #1;
      check("R7 mid-run reset enables", int'(reg_rdata), 8'h80);
      @(negedge clk); rst_n = 1'b1;
      expect_read(1'b0, 8'h00, "R7 flags stay clear");

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule